// File: doc/BRIEF.md
# Lockable Address-Latched Bank Controller

This block sits on the bus of an 8-bit CPU and steers the upper address lines of a program ROM. Every CPU write into the upper half of the address space is treated as a register write. The configuration comes from the write address, not the data:

- an outer bank number,
- a layout select,
- a mirroring bit,
- a lock flag.

Once the lock flag is set, the configuration is frozen until a reset. The data path still sets an inner bank number on every write. That value is the written byte ANDed with the ROM byte present at the same address, which models the wired-AND contention of a real bus conflict.

The block drives the 16 KiB bank number for the lower window (0x8000-0xBFFF) and for the upper window (0xC000-0xFFFF), plus a nametable mirroring select. Two layouts exist:

- **Whole layout:** one 32 KiB bank is expressed as an even/odd pair of 16 KiB banks.
- **Split layout:** the lower window is switchable and the upper window is fixed to the last bank of the outer group.

Two resets are provided:

- **Power-on:** clears everything.
- **Soft reset:** clears only the configuration and keeps the inner bank.

Top module: `bankctl_top`

## Requirements
- R1: A write with `wr_en` high and `cpu_addr[15]` low (address below 0x8000) changes no register and no output.
- R2: An unlocked write with `cpu_addr[15]` high captures these fields from the address:
  - the outer bank from `cpu_addr[2:0]`,
  - the layout from `cpu_addr[3]` (0 = split, 1 = whole),
  - the mirroring bit from `cpu_addr[4]`,
  - the lock flag from `cpu_addr[5]`.
- R3: While the lock flag is set, a write leaves the outer bank, layout, mirroring bit and lock flag unchanged.
- R4: Every write with `cpu_addr[15]` high loads the inner bank with `(cpu_data & rom_data)[2:0]`, whether the block is locked or not.
- R5: In the whole layout, `bank_lo_o = {outer, inner[1:0], 0}` and `bank_hi_o = {outer, inner[1:0], 1}`.
- R6: In the split layout, `bank_lo_o = {outer, inner}` and `bank_hi_o = {outer, 3'b111}`.
- R7: `mirror_o` is the inverse of the stored mirroring bit.
- R8: `por` clears every register, so the outputs become `bank_lo_o = 0`, `bank_hi_o = 7` and `mirror_o = 1`.
- R9: `soft_rst` clears the outer bank, layout, mirroring bit and lock flag, and keeps the inner bank. After a soft reset, writes are accepted again.
- R10: Registers update on the clock edge that samples `wr_en` high, and the outputs follow one clock later. A reset in the same cycle as a write wins, and that write is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous power-on clear, active high |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| wr_en | input | 1 | CPU write strobe, sampled at the clock edge |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| rom_data | input | 8 | ROM byte present at `cpu_addr` |
| bank_lo_o | output | 6 | 16 KiB bank number for 0x8000-0xBFFF |
| bank_hi_o | output | 6 | 16 KiB bank number for 0xC000-0xFFFF |
| mirror_o | output | 1 | Nametable mirroring select |

## Verification
Each piece of internal state is directly visible at the ports:

- The outer bank, layout and inner bank feed straight into the two bank outputs.
- The mirroring bit appears at `mirror_o`.

So a wrong value shows up one clock after the write that caused it.

The lock flag has no output of its own. A wrong lock state is therefore only seen at the next write to the window, when the configuration either fails to freeze or freezes when it should not. The bench always follows a lock with such a write.

A soft reset that clears the inner bank shows up at once in the low bits of `bank_lo_o`.

// File: rtl/bankctl_pkg.sv
package bankctl_pkg;
  // Bank layout selected by the address-captured layout bit
  typedef enum logic {
    LAYOUT_SPLIT = 1'b0,  // switchable low window, fixed high window
    LAYOUT_WHOLE = 1'b1   // one 32 KiB bank over both windows
  } layout_e;
endpackage

// File: rtl/bankctl_decode.sv
module bankctl_decode #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int OUTER_W = 3,
  parameter int INNER_W = 3
) (
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_data,
  input  logic [DATA_W-1:0]  rom_data,
  output logic               hit,
  output logic [OUTER_W-1:0] fld_outer,
  output logic               fld_layout,
  output logic               fld_mirr,
  output logic               fld_lock,
  output logic [INNER_W-1:0] conflict_val
);
  localparam int LAYOUT_BIT = OUTER_W;
  localparam int MIRR_BIT   = OUTER_W + 1;
  localparam int LOCK_BIT   = OUTER_W + 2;

  logic [DATA_W-1:0] bus_and;

  always_comb begin
    hit          = wr_en & cpu_addr[ADDR_W-1];
    fld_outer    = cpu_addr[OUTER_W-1:0];
    fld_layout   = cpu_addr[LAYOUT_BIT];
    fld_mirr     = cpu_addr[MIRR_BIT];
    fld_lock     = cpu_addr[LOCK_BIT];
    bus_and      = cpu_data & rom_data;
    conflict_val = bus_and[INNER_W-1:0];
  end

  logic unused_bits;
  assign unused_bits = ^{cpu_addr[ADDR_W-2:LOCK_BIT+1], bus_and[DATA_W-1:INNER_W]};
endmodule

// File: rtl/bankctl_regs.sv
module bankctl_regs
  import bankctl_pkg::*;
#(
  parameter int OUTER_W = 3,
  parameter int INNER_W = 3
) (
  input  logic               clk,
  input  logic               por,
  input  logic               soft_rst,
  input  logic               hit,
  input  logic [OUTER_W-1:0] fld_outer,
  input  logic               fld_layout,
  input  logic               fld_mirr,
  input  logic               fld_lock,
  input  logic [INNER_W-1:0] conflict_val,
  output logic [OUTER_W-1:0] outer_q,
  output layout_e            layout_q,
  output logic               mirr_q,
  output logic               lock_q,
  output logic [INNER_W-1:0] inner_q
);
  always_ff @(posedge clk) begin
    if (por) begin
      outer_q  <= '0;
      layout_q <= LAYOUT_SPLIT;
      mirr_q   <= 1'b0;
      lock_q   <= 1'b0;
      inner_q  <= '0;
    end else if (soft_rst) begin
      outer_q  <= '0;
      layout_q <= LAYOUT_SPLIT;
      mirr_q   <= 1'b0;
      lock_q   <= 1'b0;
    end else if (hit) begin
      inner_q <= conflict_val;
      if (!lock_q) begin
        outer_q  <= fld_outer;
        layout_q <= layout_e'(fld_layout);
        mirr_q   <= fld_mirr;
        lock_q   <= fld_lock;
      end
    end
  end

  // R3
  lock_hold_chk: assert property (@(posedge clk) disable iff (por)
    (lock_q && !soft_rst) |=> ($stable(outer_q) && $stable(layout_q) && $stable(mirr_q) && lock_q));

  // R4
  inner_load_chk: assert property (@(posedge clk) disable iff (por)
    (hit && !soft_rst) |=> (inner_q == $past(conflict_val)));

  // R9
  soft_keep_chk: assert property (@(posedge clk) disable iff (por)
    soft_rst |=> ((inner_q == $past(inner_q)) && !lock_q && (outer_q == '0) && !mirr_q));
endmodule

// File: rtl/bankctl_map.sv
module bankctl_map
  import bankctl_pkg::*;
#(
  parameter int OUTER_W = 3,
  parameter int INNER_W = 3,
  localparam int BANK_W = OUTER_W + INNER_W
) (
  input  logic               clk,
  input  logic               por,
  input  logic [OUTER_W-1:0] outer_q,
  input  layout_e            layout_q,
  input  logic               mirr_q,
  input  logic [INNER_W-1:0] inner_q,
  output logic [BANK_W-1:0]  bank_lo_o,
  output logic [BANK_W-1:0]  bank_hi_o,
  output logic               mirror_o
);
  localparam logic [BANK_W-1:0] HI_RESET = {{OUTER_W{1'b0}}, {INNER_W{1'b1}}};

  logic [BANK_W-1:0] lo_d, hi_d;

  always_comb begin
    if (layout_q == LAYOUT_WHOLE) begin
      lo_d = {outer_q, inner_q[INNER_W-2:0], 1'b0};
      hi_d = {outer_q, inner_q[INNER_W-2:0], 1'b1};
    end else begin
      lo_d = {outer_q, inner_q};
      hi_d = {outer_q, {INNER_W{1'b1}}};
    end
  end

  always_ff @(posedge clk) begin
    if (por) begin
      bank_lo_o <= '0;
      bank_hi_o <= HI_RESET;
      mirror_o  <= 1'b1;
    end else begin
      bank_lo_o <= lo_d;
      bank_hi_o <= hi_d;
      mirror_o  <= ~mirr_q;
    end
  end

  // R7
  mirr_inv_chk: assert property (@(posedge clk) disable iff (por)
    1'b1 |=> (mirror_o == !$past(mirr_q)));

  // R6
  split_hi_chk: assert property (@(posedge clk) disable iff (por)
    (layout_q == LAYOUT_SPLIT) |=> (bank_hi_o[INNER_W-1:0] == {INNER_W{1'b1}}));

  // R5
  whole_pair_chk: assert property (@(posedge clk) disable iff (por)
    (layout_q == LAYOUT_WHOLE) |=> ((bank_hi_o == (bank_lo_o | 1)) && !bank_lo_o[0]));
endmodule

// File: rtl/bankctl_top.sv
module bankctl_top
  import bankctl_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int OUTER_W = 3,
  parameter int INNER_W = 3,
  localparam int BANK_W = OUTER_W + INNER_W
) (
  input  logic              clk,
  input  logic              por,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic [DATA_W-1:0] rom_data,
  output logic [BANK_W-1:0] bank_lo_o,
  output logic [BANK_W-1:0] bank_hi_o,
  output logic              mirror_o
);
  logic               hit, fld_layout, fld_mirr, fld_lock;
  logic [OUTER_W-1:0] fld_outer;
  logic [INNER_W-1:0] conflict_val;
  logic [OUTER_W-1:0] outer_q;
  layout_e            layout_q;
  logic               mirr_q, lock_q;
  logic [INNER_W-1:0] inner_q;

  bankctl_decode #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .OUTER_W (OUTER_W),
    .INNER_W (INNER_W)
  ) u_decode (
    .wr_en        (wr_en),
    .cpu_addr     (cpu_addr),
    .cpu_data     (cpu_data),
    .rom_data     (rom_data),
    .hit          (hit),
    .fld_outer    (fld_outer),
    .fld_layout   (fld_layout),
    .fld_mirr     (fld_mirr),
    .fld_lock     (fld_lock),
    .conflict_val (conflict_val)
  );

  bankctl_regs #(
    .OUTER_W (OUTER_W),
    .INNER_W (INNER_W)
  ) u_regs (
    .clk          (clk),
    .por          (por),
    .soft_rst     (soft_rst),
    .hit          (hit),
    .fld_outer    (fld_outer),
    .fld_layout   (fld_layout),
    .fld_mirr     (fld_mirr),
    .fld_lock     (fld_lock),
    .conflict_val (conflict_val),
    .outer_q      (outer_q),
    .layout_q     (layout_q),
    .mirr_q       (mirr_q),
    .lock_q       (lock_q),
    .inner_q      (inner_q)
  );

  bankctl_map #(
    .OUTER_W (OUTER_W),
    .INNER_W (INNER_W)
  ) u_map (
    .clk       (clk),
    .por       (por),
    .outer_q   (outer_q),
    .layout_q  (layout_q),
    .mirr_q    (mirr_q),
    .inner_q   (inner_q),
    .bank_lo_o (bank_lo_o),
    .bank_hi_o (bank_hi_o),
    .mirror_o  (mirror_o)
  );

  // R1
  below_win_chk: assert property (@(posedge clk) disable iff (por)
    (wr_en && !cpu_addr[ADDR_W-1] && !soft_rst) |=>
      ($stable(inner_q) && $stable(outer_q) && $stable(layout_q) && $stable(mirr_q) && $stable(lock_q)));

  // R8
  por_clear_chk: assert property (@(posedge clk)
    por |=> ((inner_q == '0) && (outer_q == '0) && !lock_q && !mirr_q && (layout_q == LAYOUT_SPLIT)));
endmodule

// File: tb/tb_bankctl_top.sv
`timescale 1ns/1ps
module tb_bankctl_top;
  localparam int BANK_W = 6;
  localparam int EXP_W  = 2 * BANK_W + 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        por = 1'b1, soft_rst = 1'b0, wr_en = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0, rom_data = '0;
  logic [BANK_W-1:0] bank_lo_o, bank_hi_o;
  logic        mirror_o;

  bankctl_top dut (
    .clk (clk), .por (por), .soft_rst (soft_rst), .wr_en (wr_en),
    .cpu_addr (cpu_addr), .cpu_data (cpu_data), .rom_data (rom_data),
    .bank_lo_o (bank_lo_o), .bank_hi_o (bank_hi_o), .mirror_o (mirror_o)
  );

  logic [EXP_W-1:0] exp_q[$];
  string            tag_q[$];
  int checks = 0, failures = 0;
  bit done = 1'b0;

  // reference model state
  bit [2:0] m_outer, m_inner;
  bit       m_whole, m_mirr, m_lock;

  function automatic logic [EXP_W-1:0] model_out();
    logic [BANK_W-1:0] lo, hi;
    if (m_whole) begin
      lo = {m_outer, m_inner[1:0], 1'b0};
      hi = {m_outer, m_inner[1:0], 1'b1};
    end else begin
      lo = {m_outer, m_inner};
      hi = {m_outer, 3'b111};
    end
    return {lo, hi, ~m_mirr};
  endfunction

  task automatic push(input string tag);
    exp_q.push_back(model_out());
    tag_q.push_back(tag);
  endtask

  // monitor: pops each expected item and compares it with the ports
  initial begin
    forever begin
      logic [EXP_W-1:0] e, a;
      string t;
      wait (exp_q.size() > 0);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {bank_lo_o, bank_hi_o, mirror_o};
      checks++;
      if (a !== e) begin
        failures++;
        $display("FAIL %s: actual lo=%0d hi=%0d mir=%0b expected lo=%0d hi=%0d mir=%0b",
                 t, a[EXP_W-1:BANK_W+1], a[BANK_W:1], a[0],
                 e[EXP_W-1:BANK_W+1], e[BANK_W:1], e[0]);
      end
    end
  end

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, input logic [7:0] r,
                           input string tag, input bit chk_old);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; rom_data = r; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (chk_old) push("R10 outputs hold one cycle after write");
    if (a[15]) begin
      m_inner = d[2:0] & r[2:0];
      if (!m_lock) begin
        m_outer = a[2:0]; m_whole = a[3]; m_mirr = a[4]; m_lock = a[5];
      end
    end
    @(negedge clk);
    push(tag);
  endtask

  task automatic do_soft(input bit with_write, input string tag);
    @(negedge clk);
    soft_rst = 1'b1;
    if (with_write) begin
      cpu_addr = 16'h803F; cpu_data = 8'hFF; rom_data = 8'hFF; wr_en = 1'b1;
    end
    @(negedge clk);
    soft_rst = 1'b0; wr_en = 1'b0;
    m_outer = 0; m_whole = 0; m_mirr = 0; m_lock = 0;
    @(negedge clk);
    push(tag);
  endtask

  task automatic do_por(input string tag);
    @(negedge clk);
    por = 1'b1;
    @(negedge clk);
    por = 1'b0;
    m_outer = 0; m_whole = 0; m_mirr = 0; m_lock = 0; m_inner = 0;
    @(negedge clk);
    push(tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_outer = 0; m_inner = 0; m_whole = 0; m_mirr = 0; m_lock = 0;
    repeat (3) @(negedge clk);
    por = 1'b0;
    @(negedge clk);
    push("R8 power-on state");
    cpu_write(16'h8005, 8'hFF, 8'h06, "R2 R6 split capture", 1'b0);
    cpu_write(16'h8005, 8'h07, 8'h03, "R4 bus conflict AND", 1'b1);
    cpu_write(16'h801B, 8'hFF, 8'hFE, "R5 R7 whole layout mirror", 1'b0);
    cpu_write(16'h7FFF, 8'hFF, 8'hFF, "R1 write below window ignored", 1'b0);
    cpu_write(16'h4000, 8'h00, 8'h00, "R1 second low write ignored", 1'b0);
    cpu_write(16'h8022, 8'h01, 8'hFF, "R2 lock capture", 1'b0);
    cpu_write(16'hFFFF, 8'h04, 8'h0C, "R3 R4 locked write keeps config", 1'b0);
    cpu_write(16'h9018, 8'h02, 8'h02, "R3 second locked write", 1'b0);
    do_soft(1'b0, "R9 soft reset keeps inner");
    cpu_write(16'h800F, 8'h05, 8'h07, "R9 unlocked after soft reset", 1'b0);
    do_soft(1'b1, "R10 reset wins over same-cycle write");
    cpu_write(16'hC006, 8'hF3, 8'hFF, "R6 split high window fixed", 1'b0);
    do_por("R8 power-on clears inner too");
    wait (exp_q.size() == 0);
    #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule